// File: doc/BRIEF.md
# Differential Scan Channel Sequencer

This block produces the order in which input pairs of a multichannel converter are selected when the converter works differentially. A start pulse latches a 4-bit channel code, a pseudo-differential flag and a scan flag. The three upper code bits name an adjacent pair of inputs (2n, 2n+1). The lowest code bit picks which member of the pair is the positive one. With the scan flag clear, one step is issued for the named pair. With it set, the block walks the pairs from pair 0 up to and including the named pair. This moves the input address up by two per step.

Each step is presented on a positive index, a negative index and two ground flags, qualified by a valid level. Valid stays high until the downstream converter model acknowledges the step. When the pseudo-differential flag is set, the highest pair is measured against ground instead of against its odd input. Codes beyond the highest pair are refused with a one-cycle invalid pulse. A build-time pair count of two models the reduced four-input variant, in which the upper code bits have no effect.

Top module: `diff_scan_seq`

## Requirements
- R1: After synchronous reset, sel_valid, scan_done and code_invalid are all 0.
- R2: With scan_en = 0 and a legal code c, exactly one step is issued for pair n = c[3:1]. If c[0] = 0, pos_idx = 2n and neg_idx = 2n+1. If c[0] = 1, pos_idx = 2n+1 and neg_idx = 2n.
- R3: With NUM_PAIRS = 6, codes 12 to 15 are illegal. After the start edge, code_invalid is 1 for exactly one cycle, and no step and no scan_done follow.
- R4: With scan_en = 1, steps are issued for pairs 0, 1, ... up to c[3:1] in ascending order, so the even input index rises by 2 per step.
- R5: The polarity taken from c[0] at start applies to every step of that scan.
- R6: While sel_valid = 1 and step_ack = 0, sel_valid stays 1 and all selection outputs stay unchanged.
- R7: The cycle after the acknowledge of the last step, scan_done = 1 and sel_valid = 0. One cycle later scan_done returns to 0.
- R8: A start pulse during an active scan has no effect on the current or following steps.
- R9: With pseudo_en = 1, a step on the top pair (NUM_PAIRS-1) reads its even input against ground. For c[0] = 0: pos_idx = even input, neg_gnd = 1, neg_idx = 0. For c[0] = 1: pos_gnd = 1, pos_idx = 0, neg_idx = even input. Other pairs are unaffected, and the two ground flags are never both 1.
- R10: With NUM_PAIRS = 2, code bits 3 and 2 have no effect, every code is legal, and the top pair is pair 1 (inputs 2 and 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken only while idle |
| code | input | 4 | Channel code: bits 3..1 pair, bit 0 polarity |
| pseudo_en | input | 1 | Top pair reads against ground |
| scan_en | input | 1 | 1: walk pairs 0..limit, 0: single pair |
| step_ack | input | 1 | Downstream accepts the current step |
| sel_valid | output | 1 | A step is presented |
| pos_idx | output | 4 | Positive input index |
| neg_idx | output | 4 | Negative input index |
| pos_gnd | output | 1 | Positive side is ground |
| neg_gnd | output | 1 | Negative side is ground |
| scan_done | output | 1 | One-cycle pulse after the last acknowledge |
| code_invalid | output | 1 | One-cycle pulse for an illegal code |

## Verification
The hardest situation to reach from the ports is a start pulse that arrives while a scan is stalled waiting for an acknowledge. A second start carrying a different code then has a chance to corrupt the latched limit or polarity. The stimulus holds step_ack low for several cycles on the first step of a top-pair scan. During that window it pulses start with another code, then checks that every following step and the final done pulse match the original request. Sweeps over all codes, both flags and varied acknowledge delays on both pair counts cover the rest.

// File: rtl/dss_pkg.sv
package dss_pkg;

    localparam int CODE_W = 4;
    localparam int IDX_W  = 4;
    localparam int PAIR_W = 3;

    typedef logic [PAIR_W-1:0] pair_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } state_t;

    // Decoded request from the channel code
    typedef struct packed {
        logic  legal;
        pair_t limit;
        logic  swap;
    } req_t;

    // Selection presented to the converter
    typedef struct packed {
        logic [IDX_W-1:0] pos;
        logic [IDX_W-1:0] neg;
        logic             pos_gnd;
        logic             neg_gnd;
    } sel_t;

    function automatic sel_t pair_sel(pair_t p, logic swap, logic to_gnd);
        sel_t             s;
        logic [IDX_W-1:0] even_in;
        logic [IDX_W-1:0] odd_in;
        even_in   = {p, 1'b0};
        odd_in    = {p, 1'b1};
        s.pos_gnd = 1'b0;
        s.neg_gnd = 1'b0;
        if (to_gnd) begin
            if (swap) begin
                s.pos_gnd = 1'b1;
                s.pos     = '0;
                s.neg     = even_in;
            end else begin
                s.neg_gnd = 1'b1;
                s.pos     = even_in;
                s.neg     = '0;
            end
        end else if (swap) begin
            s.pos = odd_in;
            s.neg = even_in;
        end else begin
            s.pos = even_in;
            s.neg = odd_in;
        end
        return s;
    endfunction

endpackage

// File: rtl/dss_decode.sv
module dss_decode
    import dss_pkg::*;
#(
    parameter int NUM_PAIRS = 6
) (
    input  logic [CODE_W-1:0] code,
    output req_t              req
);
    localparam int PAIR_BITS = (NUM_PAIRS <= 2) ? 1 : $clog2(NUM_PAIRS);

    pair_t raw;

    // Pair bits above the used range are tied low
    for (genvar i = 0; i < PAIR_W; i++) begin : g_bit
        if (i < PAIR_BITS) begin : g_used
            assign raw[i] = code[i+1];
        end else begin : g_tied
            assign raw[i] = 1'b0;
        end
    end

    always_comb begin
        req.limit = raw;
        req.swap  = code[0];
        req.legal = (int'(raw) < NUM_PAIRS);
    end

endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
    import dss_pkg::*;
#(
    parameter int NUM_PAIRS = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  req_t  req,
    input  logic  pseudo_en,
    input  logic  scan_en,
    input  logic  step_ack,
    output logic  busy,
    output pair_t cur_pair,
    output logic  cur_swap,
    output logic  cur_pseudo,
    output logic  done,
    output logic  bad_code
);
    state_t state_q;
    pair_t  cur_q;
    pair_t  last_q;
    logic   swap_q;
    logic   pseudo_q;
    logic   done_q;
    logic   bad_q;
    logic   at_last;

    assign at_last = (cur_q == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            last_q   <= '0;
            swap_q   <= 1'b0;
            pseudo_q <= 1'b0;
            done_q   <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            bad_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (!req.legal) begin
                            bad_q <= 1'b1;
                        end else begin
                            state_q  <= ST_RUN;
                            cur_q    <= scan_en ? pair_t'(0) : req.limit;
                            last_q   <= req.limit;
                            swap_q   <= req.swap;
                            pseudo_q <= pseudo_en;
                        end
                    end
                end
                ST_RUN: begin
                    if (step_ack) begin
                        if (at_last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            cur_q <= cur_q + pair_t'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == ST_RUN);
    assign cur_pair   = cur_q;
    assign cur_swap   = swap_q;
    assign cur_pseudo = pseudo_q;
    assign done       = done_q;
    assign bad_code   = bad_q;

endmodule

// File: rtl/dss_select.sv
module dss_select
    import dss_pkg::*;
#(
    parameter int NUM_PAIRS = 6
) (
    input  pair_t cur_pair,
    input  logic  cur_swap,
    input  logic  cur_pseudo,
    output sel_t  sel
);
    localparam pair_t TOP_PAIR = pair_t'(NUM_PAIRS - 1);

    logic to_gnd;

    always_comb begin
        to_gnd = cur_pseudo && (cur_pair == TOP_PAIR);
        sel    = pair_sel(cur_pair, cur_swap, to_gnd);
    end

endmodule

// File: rtl/diff_scan_seq.sv
module diff_scan_seq
    import dss_pkg::*;
#(
    parameter int NUM_PAIRS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    input  logic              pseudo_en,
    input  logic              scan_en,
    input  logic              step_ack,
    output logic              sel_valid,
    output logic [IDX_W-1:0]  pos_idx,
    output logic [IDX_W-1:0]  neg_idx,
    output logic              pos_gnd,
    output logic              neg_gnd,
    output logic              scan_done,
    output logic              code_invalid
);
    req_t  req;
    pair_t cur_pair;
    logic  cur_swap;
    logic  cur_pseudo;
    logic  busy;
    sel_t  sel;

    dss_decode #(.NUM_PAIRS(NUM_PAIRS)) u_decode (
        .code (code),
        .req  (req)
    );

    dss_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req        (req),
        .pseudo_en  (pseudo_en),
        .scan_en    (scan_en),
        .step_ack   (step_ack),
        .busy       (busy),
        .cur_pair   (cur_pair),
        .cur_swap   (cur_swap),
        .cur_pseudo (cur_pseudo),
        .done       (scan_done),
        .bad_code   (code_invalid)
    );

    dss_select #(.NUM_PAIRS(NUM_PAIRS)) u_select (
        .cur_pair   (cur_pair),
        .cur_swap   (cur_swap),
        .cur_pseudo (cur_pseudo),
        .sel        (sel)
    );

    assign sel_valid = busy;
    assign pos_idx   = sel.pos;
    assign neg_idx   = sel.neg;
    assign pos_gnd   = sel.pos_gnd;
    assign neg_gnd   = sel.neg_gnd;

endmodule

// File: rtl/dss_checker.sv
module dss_checker
    import dss_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             step_ack,
    input logic             sel_valid,
    input logic [IDX_W-1:0] pos_idx,
    input logic [IDX_W-1:0] neg_idx,
    input logic             pos_gnd,
    input logic             neg_gnd,
    input logic             scan_done,
    input logic             code_invalid
);
    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
        sel_valid && !step_ack |=> sel_valid && $stable(pos_idx) && $stable(neg_idx)
                                   && $stable(pos_gnd) && $stable(neg_gnd));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        sel_valid && start && !step_ack |=> sel_valid && $stable(pos_idx) && $stable(neg_idx));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> !sel_valid);

    assert_invalid_no_step_R3: assert property (@(posedge clk) disable iff (rst)
        code_invalid |-> !sel_valid && !scan_done);

    assert_gnd_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> $onehot0({pos_gnd, neg_gnd}));

    assert_pair_adjacent_R2: assert property (@(posedge clk) disable iff (rst)
        sel_valid && !pos_gnd && !neg_gnd |->
            (pos_idx[IDX_W-1:1] == neg_idx[IDX_W-1:1]) && (pos_idx[0] != neg_idx[0]));

    assert_polarity_kept_R5: assert property (@(posedge clk) disable iff (rst)
        sel_valid && $past(sel_valid) && !pos_gnd && !neg_gnd
            && !$past(pos_gnd) && !$past(neg_gnd) |-> pos_idx[0] == $past(pos_idx[0]));

endmodule

bind diff_scan_seq dss_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .step_ack     (step_ack),
    .sel_valid    (sel_valid),
    .pos_idx      (pos_idx),
    .neg_idx      (neg_idx),
    .pos_gnd      (pos_gnd),
    .neg_gnd      (neg_gnd),
    .scan_done    (scan_done),
    .code_invalid (code_invalid)
);

// File: tb/diff_scan_seq_test.sv
module diff_scan_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] code = 4'd0;
    logic       pseudo_en = 1'b0;
    logic       scan_en = 1'b0;
    logic       step_ack = 1'b0;
    logic       tgt = 1'b0;   // 0: six-pair unit, 1: two-pair unit

    logic       v_f, pg_f, ng_f, d_f, i_f;
    logic [3:0] p_f, n_f;
    logic       v_r, pg_r, ng_r, d_r, i_r;
    logic [3:0] p_r, n_r;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    diff_scan_seq #(.NUM_PAIRS(6)) uut (
        .clk(clk), .rst(rst), .start(start && !tgt), .code(code),
        .pseudo_en(pseudo_en), .scan_en(scan_en), .step_ack(step_ack && !tgt),
        .sel_valid(v_f), .pos_idx(p_f), .neg_idx(n_f), .pos_gnd(pg_f),
        .neg_gnd(ng_f), .scan_done(d_f), .code_invalid(i_f)
    );

    diff_scan_seq #(.NUM_PAIRS(2)) uut_r (
        .clk(clk), .rst(rst), .start(start && tgt), .code(code),
        .pseudo_en(pseudo_en), .scan_en(scan_en), .step_ack(step_ack && tgt),
        .sel_valid(v_r), .pos_idx(p_r), .neg_idx(n_r), .pos_gnd(pg_r),
        .neg_gnd(ng_r), .scan_done(d_r), .code_invalid(i_r)
    );

    wire       o_v  = tgt ? v_r  : v_f;
    wire [3:0] o_p  = tgt ? p_r  : p_f;
    wire [3:0] o_n  = tgt ? n_r  : n_f;
    wire       o_pg = tgt ? pg_r : pg_f;
    wire       o_ng = tgt ? ng_r : ng_f;
    wire       o_d  = tgt ? d_r  : d_f;
    wire       o_i  = tgt ? i_r  : i_f;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_step(input string tag, input int p, input bit swp, input bit gnd);
        int ep, en, epg, eng;
        if (gnd) begin
            epg = swp ? 1 : 0;
            eng = swp ? 0 : 1;
            ep  = swp ? 0 : 2 * p;
            en  = swp ? 2 * p : 0;
        end else begin
            epg = 0;
            eng = 0;
            ep  = swp ? 2 * p + 1 : 2 * p;
            en  = swp ? 2 * p : 2 * p + 1;
        end
        check({tag, " valid"}, o_v, 1);
        check({tag, " pos_idx"}, o_p, ep);
        check({tag, " neg_idx"}, o_n, en);
        check({tag, " pos_gnd"}, o_pg, epg);
        check({tag, " neg_gnd"}, o_ng, eng);
        if (!gnd) check("R5 polarity bit", o_p[0], swp ? 1 : 0);
    endtask

    // Run one request on the selected unit; waits = cycles without ack per step.
    task automatic do_op(input int c, input bit ps, input bit sc, input int waits, input bit poke);
        int    npairs = tgt ? 2 : 6;
        int    lim    = tgt ? ((c >> 1) & 1) : ((c >> 1) & 7);
        bit    swp    = c[0];
        bit    illegal = (lim >= npairs);
        int    first  = sc ? 0 : lim;
        string tag;
        @(negedge clk);
        code = 4'(c); pseudo_en = ps; scan_en = sc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (illegal) begin
            check("R3 invalid pulse", o_i, 1);
            check("R3 no valid", o_v, 0);
            @(negedge clk);
            check("R3 invalid ends", o_i, 0);
            check("R3 still idle", o_v, 0);
            check("R3 no done", o_d, 0);
            return;
        end
        check("R3 legal code no invalid", o_i, 0);
        for (int p = first; p <= lim; p++) begin
            bit gnd = ps && (p == npairs - 1);
            if (tgt) tag = "R10";
            else if (gnd) tag = "R9";
            else if (sc) tag = "R4";
            else tag = "R2";
            check_step(tag, p, swp, gnd);
            for (int w = 0; w < waits; w++) begin
                if (poke && p == first && w == 0) begin
                    code = 4'd1; scan_en = 1'b0; pseudo_en = 1'b0; start = 1'b1;
                end
                @(negedge clk);
                start = 1'b0;
                check_step((poke ? "R8" : "R6"), p, swp, gnd);
            end
            step_ack = 1'b1;
            @(negedge clk);
            step_ack = 1'b0;
        end
        check("R7 done pulse", o_d, 1);
        check("R7 valid low at done", o_v, 0);
        @(negedge clk);
        check("R7 done ends", o_d, 0);
        check("R7 idle after done", o_v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset valid", v_f, 0);
        check("R1 reset done", d_f, 0);
        check("R1 reset invalid", i_f, 0);
        check("R1 reset valid small", v_r, 0);
        check("R1 reset done small", d_r, 0);
        check("R1 reset invalid small", i_r, 0);

        for (int t = 0; t < 2; t++) begin
            tgt = t[0];
            for (int c = 0; c < 16; c++)
                for (int ps = 0; ps < 2; ps++)
                    for (int sc = 0; sc < 2; sc++)
                        do_op(c, ps[0], sc[0], (c + ps + sc) % 3, 1'b0);
        end

        // R8: start with another code while the first step waits for ack
        tgt = 1'b0;
        do_op(10, 1'b0, 1'b1, 2, 1'b1);
        do_op(11, 1'b1, 1'b1, 3, 1'b1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule